// File: doc/BRIEF.md
# Banked Envelope Sample Memory

This block accepts envelope samples one at a time on a valid/ready stream and distributes them across `BANKS` parallel 16-bit memory banks. Each 32-bit stream word carries a complex sample. The low half is the real part and the high half is the imaginary part. Consecutive accepted samples land in consecutive banks. The bank address steps forward once every pass across all banks. A wide read port on a separate, possibly unrelated, clock can then fetch one sample from every bank in the same cycle. Each parallel output channel thus receives its own sample on every clock.

Two plain control inputs govern the write side. A start address sets where filling begins. A write-enable level gates all writes, and its rising edge restarts the fill pattern. Back-pressure is simple: `s_ready` follows the write-enable level. A word is stored only in a cycle where `s_valid` and `s_ready` are both high. A producer that holds `s_valid` while `s_ready` is low stalls, and nothing is written.

The `COMPLEX` parameter selects the storage kind at elaboration. With complex storage, a second set of banks holds the imaginary parts. A channel's real and imaginary banks share one enable and one address. With real-only storage, the imaginary banks are not built and the imaginary read bus is constant zero.

Top module: `envl_loader`

## Requirements
- R1: For a stored word, bits [15:0] go to the real bank and bits [31:16] go to the imaginary bank of the same channel, at the same address.
- R2: Counting from the last reload, accepted sample k is stored in bank (k mod BANKS), at address start + floor(k / BANKS). Only one bank is written per cycle.
- R3: `s_ready` equals `wr_en`. While `wr_en` is low, no word is stored and the write position does not move, whatever `s_valid` does.
- R4: A word is committed only in a cycle with `s_valid` and `s_ready` both high. Cycles with `s_valid` low neither write nor advance the position.
- R5: In the cycle where `wr_en` rises, the position reloads to bank 0 at `start_addr`. A word accepted in that same cycle is stored there. Changes to `start_addr` while `wr_en` stays high have no effect.
- R6: A `rd_addr` value applied before read-clock edge k appears on `rd_real` and `rd_imag` after edge k+1, a latency of two edges. Lane i (bits 16i+15 down to 16i) holds bank i.
- R7: With `COMPLEX` = 0, `rd_imag` is zero at all times.
- R8: While `rd_rst_n` is low, both read buses are zero, and memory contents survive the reset. A low `wr_rst_n` clears the write position and edge history, so the first `wr_en` level seen after release acts as a rising edge.
- R9: The bank address wraps from 2^ADDR_W - 1 back to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wr_clk | input | 1 | Stream / write clock |
| wr_rst_n | input | 1 | Active-low reset, write domain |
| s_valid | input | 1 | Sample word offered |
| s_ready | output | 1 | Sample word can be taken (follows wr_en) |
| s_data | input | 32 | [31:16] imaginary, [15:0] real |
| start_addr | input | ADDR_W | Fill start address, loaded on wr_en rise |
| wr_en | input | 1 | Write gate level |
| rd_clk | input | 1 | Read clock |
| rd_rst_n | input | 1 | Active-low reset, read domain |
| rd_addr | input | ADDR_W | Shared read address for all banks |
| rd_real | output | BANKS*16 | Real samples, one lane per bank |
| rd_imag | output | BANKS*16 | Imaginary samples, zero in real-only mode |

## Verification
The write-side properties assume a reset in the write domain before any use. They also assume that `start_addr` and `wr_en` are driven as clean levels that change only between clock edges. The stimulus changes them only on falling write-clock edges. Memory reads are checked only for addresses that have no write in flight, because the two clocks have no fixed relation. The bench meets this by holding reads that overlap a fill phase out of the comparison, and it resumes comparing only after the write side has gone idle.

// File: rtl/envl_pkg.sv
package envl_pkg;
  localparam int SAMPLE_W = 16;
  typedef logic [SAMPLE_W-1:0] sample_t;
  typedef struct packed {
    sample_t im;
    sample_t re;
  } cplx_t;
endpackage

// File: rtl/envl_writer.sv
module envl_writer
  import envl_pkg::*;
#(
  parameter int BANKS  = 8,
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              s_valid,
  output logic              s_ready,
  input  cplx_t             s_word,
  input  logic [ADDR_W-1:0] cfg_start,
  input  logic              cfg_en,
  output logic [BANKS-1:0]  bank_en,
  output logic [ADDR_W-1:0] bank_addr,
  output cplx_t             bank_word
);
  localparam int IDX_W = (BANKS > 1) ? $clog2(BANKS) : 1;

  logic              en_q;
  logic [IDX_W-1:0]  idx;
  logic [ADDR_W-1:0] addr;
  logic              rise, fire, last;
  logic [IDX_W-1:0]  cur_idx;
  logic [ADDR_W-1:0] cur_addr;

  assign s_ready  = cfg_en;
  assign rise     = cfg_en & ~en_q;
  assign fire     = s_valid & cfg_en;
  assign cur_idx  = rise ? '0 : idx;
  assign cur_addr = rise ? cfg_start : addr;
  assign last     = (cur_idx == IDX_W'(BANKS - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q <= 1'b0;
      idx  <= '0;
      addr <= '0;
    end else begin
      en_q <= cfg_en;
      if (fire) begin
        idx  <= last ? '0 : IDX_W'(cur_idx + 1'b1);
        addr <= last ? ADDR_W'(cur_addr + 1'b1) : cur_addr;
      end else if (rise) begin
        idx  <= '0;
        addr <= cfg_start;
      end
    end
  end

  for (genvar b = 0; b < BANKS; b++) begin : g_lane_en
    assign bank_en[b] = fire && (cur_idx == IDX_W'(b));
  end

  assign bank_addr = cur_addr;
  assign bank_word = s_word;

  assert_onehot_lane_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(bank_en));

  assert_gated_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (|bank_en) |-> (cfg_en && s_valid));

  assert_hold_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!fire && !rise) |=> ($stable(idx) && $stable(addr)));

  assert_reload_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rise && !fire) |=> (idx == '0 && addr == $past(cfg_start)));

  assert_advance_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !last) |=> (idx == IDX_W'($past(cur_idx) + 1'b1) && addr == $past(cur_addr)));

  assert_wrap_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && last) |=> (idx == '0 && addr == ADDR_W'($past(cur_addr) + 1'b1)));
endmodule

// File: rtl/envl_bank.sv
module envl_bank
  import envl_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              wclk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  sample_t           wdata,
  input  logic              rclk,
  input  logic              rrst_n,
  input  logic [ADDR_W-1:0] raddr,
  output sample_t           rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  sample_t mem [DEPTH];
  sample_t stage;

  always_ff @(posedge wclk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge rclk) begin
    if (!rrst_n) begin
      stage <= '0;
      rdata <= '0;
    end else begin
      stage <= mem[raddr];
      rdata <= stage;
    end
  end
endmodule

// File: rtl/envl_loader.sv
module envl_loader
  import envl_pkg::*;
#(
  parameter int BANKS   = 8,
  parameter int ADDR_W  = 6,
  parameter bit COMPLEX = 1'b1
) (
  input  logic                      wr_clk,
  input  logic                      wr_rst_n,
  input  logic                      s_valid,
  output logic                      s_ready,
  input  logic [31:0]               s_data,
  input  logic [ADDR_W-1:0]         start_addr,
  input  logic                      wr_en,
  input  logic                      rd_clk,
  input  logic                      rd_rst_n,
  input  logic [ADDR_W-1:0]         rd_addr,
  output logic [BANKS*SAMPLE_W-1:0] rd_real,
  output logic [BANKS*SAMPLE_W-1:0] rd_imag
);
  logic [BANKS-1:0]  lane_we;
  logic [ADDR_W-1:0] lane_addr;
  cplx_t             lane_word;

  envl_writer #(.BANKS(BANKS), .ADDR_W(ADDR_W)) u_wr (
    .clk      (wr_clk),
    .rst_n    (wr_rst_n),
    .s_valid  (s_valid),
    .s_ready  (s_ready),
    .s_word   (cplx_t'(s_data)),
    .cfg_start(start_addr),
    .cfg_en   (wr_en),
    .bank_en  (lane_we),
    .bank_addr(lane_addr),
    .bank_word(lane_word)
  );

  for (genvar b = 0; b < BANKS; b++) begin : g_lane
    envl_bank #(.ADDR_W(ADDR_W)) u_re (
      .wclk  (wr_clk),
      .we    (lane_we[b]),
      .waddr (lane_addr),
      .wdata (lane_word.re),
      .rclk  (rd_clk),
      .rrst_n(rd_rst_n),
      .raddr (rd_addr),
      .rdata (rd_real[b*SAMPLE_W +: SAMPLE_W])
    );
    if (COMPLEX) begin : g_cplx
      envl_bank #(.ADDR_W(ADDR_W)) u_im (
        .wclk  (wr_clk),
        .we    (lane_we[b]),
        .waddr (lane_addr),
        .wdata (lane_word.im),
        .rclk  (rd_clk),
        .rrst_n(rd_rst_n),
        .raddr (rd_addr),
        .rdata (rd_imag[b*SAMPLE_W +: SAMPLE_W])
      );
    end else begin : g_real
      assign rd_imag[b*SAMPLE_W +: SAMPLE_W] = '0;
    end
  end
endmodule

// File: tb/sim_envl_loader.sv
module sim_envl_loader;
  localparam int BANKS  = 8;
  localparam int ADDR_W = 6;
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int LW     = BANKS * 16;

  logic wr_clk = 1'b0, rd_clk = 1'b0;
  logic wr_rst_n = 1'b0, rd_rst_n = 1'b0;
  logic s_valid = 1'b0;
  logic [31:0] s_data = '0;
  logic [ADDR_W-1:0] start_addr = '0, rd_addr = '0;
  logic wr_en = 1'b0;
  logic s_ready0, s_ready1;
  logic [LW-1:0] re0, im0, re1, im1;

  always #2 wr_clk = ~wr_clk;
  always #3 rd_clk = ~rd_clk;

  envl_loader #(.BANKS(BANKS), .ADDR_W(ADDR_W), .COMPLEX(1'b1)) u0 (
    .wr_clk(wr_clk), .wr_rst_n(wr_rst_n), .s_valid(s_valid), .s_ready(s_ready0),
    .s_data(s_data), .start_addr(start_addr), .wr_en(wr_en),
    .rd_clk(rd_clk), .rd_rst_n(rd_rst_n), .rd_addr(rd_addr),
    .rd_real(re0), .rd_imag(im0));

  envl_loader #(.BANKS(BANKS), .ADDR_W(ADDR_W), .COMPLEX(1'b0)) u1 (
    .wr_clk(wr_clk), .wr_rst_n(wr_rst_n), .s_valid(s_valid), .s_ready(s_ready1),
    .s_data(s_data), .start_addr(start_addr), .wr_en(wr_en),
    .rd_clk(rd_clk), .rd_rst_n(rd_rst_n), .rd_addr(rd_addr),
    .rd_real(re1), .rd_imag(im1));

  int n_cmp = 0, n_bad = 0;
  string tag = "R8";
  bit busy = 1'b1;
  bit done = 1'b0;

  // behavioural model of stored contents and write position
  logic [15:0] mre [BANKS][DEPTH];
  logic [15:0] mim [BANKS][DEPTH];
  int m_idx = 0, m_addr = 0;
  bit m_prev = 1'b0;

  always @(posedge wr_clk) begin
    if (!wr_rst_n) begin
      m_prev = 1'b0; m_idx = 0; m_addr = 0;
    end else begin
      if (wr_en && !m_prev) begin m_idx = 0; m_addr = int'(start_addr); end
      if (wr_en && s_valid) begin
        mre[m_idx][m_addr] = s_data[15:0];
        mim[m_idx][m_addr] = s_data[31:16];
        m_idx++;
        if (m_idx == BANKS) begin m_idx = 0; m_addr = (m_addr + 1) % DEPTH; end
      end
      m_prev = wr_en;
    end
  end

  function automatic logic [LW-1:0] pack_row(input int a, input bit imag);
    logic [LW-1:0] v;
    for (int b = 0; b < BANKS; b++) v[b*16 +: 16] = imag ? mim[b][a] : mre[b][a];
    return v;
  endfunction

  task automatic check(input string req, input logic [LW-1:0] act, input logic [LW-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s at %0t: actual %h expected %h", req, $time, act, exp);
    end
  endtask

  // R3: ready follows the write gate, compared every write cycle
  always @(negedge wr_clk) if (!done) begin
    check("R3 ready0", LW'(s_ready0), LW'(wr_en));
    check("R3 ready1", LW'(s_ready1), LW'(wr_en));
  end

  // read pipeline reference: two edges from address to output (R6)
  logic [LW-1:0] ev_st_re = '0, ev_st_im = '0, ev_re = '0, ev_im = '0;
  bit ok_st = 1'b0, ok_out = 1'b0;

  always @(posedge rd_clk) begin
    if (!rd_rst_n) begin
      ev_re = '0; ev_im = '0; ev_st_re = '0; ev_st_im = '0;
      ok_out = 1'b1; ok_st = 1'b1;
    end else begin
      ev_re = ev_st_re; ev_im = ev_st_im; ok_out = ok_st;
      ok_st = !busy;
      if (!busy) begin
        ev_st_re = pack_row(int'(rd_addr), 1'b0);
        ev_st_im = pack_row(int'(rd_addr), 1'b1);
      end
    end
  end

  always @(negedge rd_clk) if (!done) begin
    if (ok_out) begin
      check({tag, " R6 R1 real"}, re0, ev_re);
      check({tag, " R6 R1 imag"}, im0, ev_im);
      check({tag, " R6 real-only lane"}, re1, ev_re);
    end
    if ($time > 10) check("R7 imag zero", im1, '0);
  end

  function automatic logic [31:0] dgen(input int k, input int salt);
    return {16'(k * 37 + salt), 16'((k ^ 16'h5A5A) + salt * 3)};
  endfunction

  task automatic wcyc(input int n);
    repeat (n) @(negedge wr_clk);
  endtask

  task automatic push(input logic [31:0] d);
    @(negedge wr_clk); s_valid = 1'b1; s_data = d;
  endtask

  task automatic idle();
    @(negedge wr_clk); s_valid = 1'b0;
  endtask

  task automatic begin_wr();
    @(negedge wr_clk); busy = 1'b1;
  endtask

  task automatic end_wr();
    @(negedge wr_clk); s_valid = 1'b0; wr_en = 1'b0;
    wcyc(4); busy = 1'b0;
  endtask

  task automatic sweep();
    for (int a = 0; a < DEPTH; a++) begin
      @(negedge rd_clk); rd_addr = ADDR_W'(a);
    end
    repeat (4) @(negedge rd_clk);
  endtask

  initial begin
    // R8: reset state of the read buses is checked by the pipeline reference
    repeat (5) @(negedge rd_clk);
    wcyc(2); wr_rst_n = 1'b1;
    @(negedge rd_clk); rd_rst_n = 1'b1;

    // R1 R2: fill every address, continuous stream
    tag = "R2 fill";
    begin_wr(); start_addr = '0; wr_en = 1'b1;
    for (int k = 0; k < BANKS * DEPTH; k++) push(dgen(k, 1));
    end_wr(); sweep();

    // R4: gaps in valid
    tag = "R4 gaps";
    begin_wr(); start_addr = ADDR_W'(10); wr_en = 1'b1;
    for (int k = 0; k < 20; k++) begin push(dgen(k, 2)); idle(); if (k % 3 == 0) idle(); end
    end_wr(); sweep();

    // R3: valid offered while gate low, nothing stored
    tag = "R3 gated";
    begin_wr(); wr_en = 1'b0; start_addr = ADDR_W'(0);
    for (int k = 0; k < 12; k++) push(dgen(k, 3));
    end_wr(); sweep();

    // R9: address wraps past the top
    tag = "R9 wrap";
    begin_wr(); start_addr = ADDR_W'(DEPTH - 2); wr_en = 1'b1;
    for (int k = 0; k < 3 * BANKS; k++) push(dgen(k, 4));
    end_wr(); sweep();

    // R5: reload on rise, start ignored while held high
    tag = "R5 reload";
    begin_wr(); start_addr = ADDR_W'(30); wr_en = 1'b1; s_valid = 1'b1; s_data = dgen(0, 5);
    for (int k = 1; k < 3; k++) push(dgen(k, 5));
    idle(); start_addr = ADDR_W'(50);
    for (int k = 3; k < 5; k++) push(dgen(k, 5));
    idle(); wr_en = 1'b0;
    @(negedge wr_clk); start_addr = ADDR_W'(40); wr_en = 1'b1;
    for (int k = 5; k < 10; k++) push(dgen(k, 5));
    end_wr(); sweep();

    // R8: write-domain reset clears position, gate level after release acts as rise
    tag = "R8 wr reset";
    begin_wr(); start_addr = ADDR_W'(12); wr_en = 1'b1;
    for (int k = 0; k < 4; k++) push(dgen(k, 6));
    idle(); wr_rst_n = 1'b0; wcyc(3); wr_rst_n = 1'b1;
    for (int k = 4; k < 9; k++) push(dgen(k, 6));
    end_wr(); sweep();

    // R8: read reset zeroes outputs but keeps contents
    tag = "R8 rd reset";
    @(negedge rd_clk); rd_addr = ADDR_W'(12);
    repeat (3) @(negedge rd_clk);
    rd_rst_n = 1'b0;
    repeat (3) @(negedge rd_clk);
    rd_rst_n = 1'b1;
    sweep();

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      done = 1'b1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule